// File: doc/BRIEF.md
# Five-Function Integer ALU

A purely combinational arithmetic logic unit for a 32-bit datapath. Two operands and a 3-bit operation code go in; a result word and three flags come out in the same cycle: Zero, CarryOut and Overflow. It provides bitwise AND, bitwise OR, addition, subtraction and set-on-less-than. Any register in front of or behind it belongs to the surrounding pipeline.

All arithmetic runs through one carry chain. Subtraction and set-on-less-than pass the second operand through an inverter and force the incoming carry to 1, which forms A + ~B + 1 = A − B. Set-on-less-than returns the raw sign bit of that difference in bit 0. This bit is not a corrected signed compare, so it gives the opposite answer when the subtraction overflows. An equality branch subtracts and then tests the Zero flag.

Top module: `alu5_core`

## Requirements
- R1: Code 3'b000 gives result = A & B, with CarryOut and Overflow low.
- R2: Code 3'b001 gives result = A | B, with CarryOut and Overflow low.
- R3: Code 3'b010 gives result = (A + B) mod 2^32, and CarryOut is bit 32 of the unsigned 33-bit sum.
- R4: Code 3'b110 gives result = (A − B) mod 2^32. It is formed as A + ~B + 1, so CarryOut is 1 exactly when A ≥ B as unsigned numbers.
- R5: Code 3'b111 gives bit 0 = bit 31 of (A − B) mod 2^32 and bits 31..1 = 0. CarryOut is the carry of that subtraction and Overflow is 0. Example: A=0x80000000, B=1 gives 0; A=0x7FFFFFFF, B=0xFFFFFFFF gives 1.
- R6: For the five defined codes, Zero is 1 exactly when all 32 result bits are 0.
- R7: Overflow is 1 for add or subtract exactly when the signed result falls outside [−2^31, 2^31−1]. It is 0 for set-on-less-than.
- R8: AND and OR never raise CarryOut or Overflow, whatever the operands.
- R9: Codes 3'b011, 3'b100 and 3'b101 give result 0 with Zero, CarryOut and Overflow all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| op_sel | input | 3 | Operation code |
| res | output | 32 | Result word |
| zero_flag | output | 1 | Result is all zeros (defined codes only) |
| carry_flag | output | 1 | Carry out of the top adder bit |
| ovf_flag | output | 1 | Signed overflow of add or subtract |

## Verification
Every operand pair is applied under all eight codes. Each code is compared with a reference that works on signed 64-bit integers and on unsigned 33-bit sums, so the bench never models the carry chain. The operands are fixed corners and a pseudo-random stream:
- 0x80000000 and 0x7FFFFFFF, against 1 and 0xFFFFFFFF, separate correct overflow detection from an inverted or missing check. They also show that set-on-less-than reports the raw sign and not a corrected compare.
- Equal operands under subtract exercise Zero after subtraction.
- 0 against 0xFFFFFFFF exercises the carry at both extremes.
- The random stream covers ordinary carry propagation through all bit positions.

// File: rtl/alu5_core.sv
`timescale 1ns/1ps
module alu5_core #(
  parameter int W = 32
) (
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic [2:0]   op_sel,
  output logic [W-1:0] res,
  output logic         zero_flag,
  output logic         carry_flag,
  output logic         ovf_flag
);

  localparam int MSB = W - 1;

  logic       binv, cin, valid;
  logic [1:0] pick;
  logic [W-1:0] bm, sum;
  logic [W:0]   cy;

  always_comb begin
    binv  = 1'b0;
    cin   = 1'b0;
    pick  = 2'd0;
    valid = 1'b1;
    case (op_sel)
      3'b000: pick = 2'd0;
      3'b001: pick = 2'd1;
      3'b010: pick = 2'd2;
      3'b110: begin binv = 1'b1; cin = 1'b1; pick = 2'd2; end
      3'b111: begin binv = 1'b1; cin = 1'b1; pick = 2'd3; end
      default: valid = 1'b0;
    endcase
  end

  assign bm = op_b ^ {W{binv}};

  always_comb begin
    cy[0] = cin;
    for (int i = 0; i < W; i++) begin
      sum[i]  = op_a[i] ^ bm[i] ^ cy[i];
      cy[i+1] = (op_a[i] & bm[i]) | (cy[i] & (op_a[i] ^ bm[i]));
    end
  end

  always_comb begin
    case (pick)
      2'd0:    res = op_a & op_b;
      2'd1:    res = op_a | op_b;
      2'd2:    res = sum;
      default: res = {{(W-1){1'b0}}, sum[MSB]};
    endcase
    if (!valid) res = '0;
  end

  assign carry_flag = valid & pick[1] & cy[W];
  assign ovf_flag   = valid & (pick == 2'd2) & (op_a[MSB] == bm[MSB]) & (sum[MSB] != op_a[MSB]);
  assign zero_flag  = valid & (res == '0);

  always_comb begin
    if (!$isunknown({op_a, op_b, op_sel})) begin
      if (op_sel == 3'b000)
        a_r1_and_subset: assert (((res & ~op_a) == '0) && ((res & ~op_b) == '0));
      if (op_sel == 3'b010)
        a_r3_add_sum: assert ({carry_flag, res} == ({1'b0, op_a} + {1'b0, op_b}));
      if (op_sel == 3'b110)
        a_r4_sub_diff: assert (res == op_a - op_b);
      if (op_sel == 3'b111)
        a_r5_slt_narrow: assert ((res[W-1:1] == '0) && !ovf_flag);
      a_r6_zero_consistent: assert (!zero_flag || (res == '0));
      if (op_sel == 3'b000 || op_sel == 3'b001)
        a_r8_logic_no_flags: assert (!carry_flag && !ovf_flag);
      if (op_sel == 3'b011 || op_sel == 3'b100 || op_sel == 3'b101)
        a_r9_unused_quiet: assert ((res == '0) && !zero_flag && !carry_flag && !ovf_flag);
    end
  end

endmodule

// File: tb/alu5_core_test.sv
`timescale 1ns/1ps
module alu5_core_test;
  localparam int W = 32;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [W-1:0] a, b, res;
  logic [2:0]   op;
  logic         zero_flag, carry_flag, ovf_flag;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  alu5_core #(.W(W)) uut (
    .op_a(a), .op_b(b), .op_sel(op),
    .res(res), .zero_flag(zero_flag), .carry_flag(carry_flag), .ovf_flag(ovf_flag)
  );

  task automatic chk(input string tag, input string what, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s op=%b a=%h b=%h actual=%h expected=%h", tag, what, op, a, b, act, exp);
    end
  endtask

  function automatic string optag(input logic [2:0] o);
    case (o)
      3'b000: return "R1";
      3'b001: return "R2";
      3'b010: return "R3";
      3'b110: return "R4";
      3'b111: return "R5";
      default: return "R9";
    endcase
  endfunction

  task automatic run(input logic [W-1:0] x, input logic [W-1:0] y, input logic [2:0] o);
    logic [W:0]   s;
    logic [W-1:0] er;
    logic         ec, ev, ez, ok;
    longint       sx, sy, sr;
    @(posedge clk);
    a <= x; b <= y; op <= o;
    @(negedge clk);
    sx = longint'($signed(x));
    sy = longint'($signed(y));
    er = '0; ec = 1'b0; ev = 1'b0; ok = 1'b1;
    case (o)
      3'b000: er = x & y;
      3'b001: er = x | y;
      3'b010: begin
        s = {1'b0, x} + {1'b0, y};
        er = s[W-1:0]; ec = s[W];
        sr = sx + sy;
        ev = (sr > 64'sd2147483647) || (sr < -64'sd2147483648);
      end
      3'b110: begin
        er = x - y; ec = (x >= y);
        sr = sx - sy;
        ev = (sr > 64'sd2147483647) || (sr < -64'sd2147483648);
      end
      3'b111: begin
        s = {1'b0, x - y};
        er = {{(W-1){1'b0}}, s[W-1]}; ec = (x >= y);
      end
      default: ok = 1'b0;
    endcase
    ez = ok && (er == '0);
    chk(optag(o), "result", res, er);
    chk(ok ? "R6" : "R9", "zero", {{(W-1){1'b0}}, zero_flag}, {{(W-1){1'b0}}, ez});
    chk((o == 3'b000 || o == 3'b001) ? "R8" : optag(o), "carry", {{(W-1){1'b0}}, carry_flag}, {{(W-1){1'b0}}, ec});
    chk(ok ? ((o == 3'b000 || o == 3'b001) ? "R8" : "R7") : "R9", "overflow",
        {{(W-1){1'b0}}, ovf_flag}, {{(W-1){1'b0}}, ev});
  endtask

  task automatic all_ops(input logic [W-1:0] x, input logic [W-1:0] y);
    for (int k = 0; k < 8; k++) run(x, y, k[2:0]);
  endtask

  initial begin
    logic [W-1:0] seed;
    logic [W-1:0] r1;
    a = '0; b = '0; op = 3'b000;
    @(negedge clk);
    // R1, R6: idle inputs give an AND of zeros with Zero high
    chk("R1", "idle result", res, '0);
    chk("R6", "idle zero", {{(W-1){1'b0}}, zero_flag}, {{(W-1){1'b0}}, 1'b1});

    all_ops(32'h8000_0000, 32'h0000_0001);   // R5 raw sign gives 0, R7 sub overflow
    all_ops(32'h7FFF_FFFF, 32'hFFFF_FFFF);   // R5 raw sign gives 1, R7 sub overflow
    all_ops(32'h7FFF_FFFF, 32'h0000_0001);   // R7 add overflow
    all_ops(32'h8000_0000, 32'h8000_0000);   // R3 carry and overflow, R4 zero diff
    all_ops(32'h0000_0005, 32'h0000_0005);   // R4, R6 equality
    all_ops(32'h0000_0000, 32'hFFFF_FFFF);   // R3, R4 carry extremes
    all_ops(32'hFFFF_FFFF, 32'hFFFF_FFFF);   // R8 logic with all ones
    all_ops(32'h0000_0003, 32'h0000_0009);   // R5 small less-than
    all_ops(32'hF0F0_F0F0, 32'h0F0F_0F0F);   // R1 disjoint, R2 all ones

    seed = 32'h1234_5678;
    for (int n = 0; n < 300; n++) begin
      seed = seed * 32'd1664525 + 32'd1013904223;
      r1 = seed;
      seed = seed * 32'd1664525 + 32'd1013904223;
      all_ops(r1, seed ^ {r1[15:0], r1[31:16]});
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule